// File: doc/BRIEF.md
# Instruction Fetch Breakpoint Comparator Bank

This block watches the processor's instruction fetch stream and raises a breakpoint request whenever the fetch address equals one of eight programmed comparator addresses. Debug software programs the comparators and a global enable through a small 32-bit register port. The port is addressed by word offset inside a 4 KB window. The same port also returns fixed identification words, which discovery software reads near the top of the window.

A comparator takes part in matching only when its mode bit selects breakpoint behaviour. The alternative mode, code remap, is not built. The remap-capability register always reads zero, which tells software that remap is absent. The control register is protected by a write key: a write to it is dropped unless the key bit is set in the same write. The breakpoint request and the index of the lowest matching comparator are registered. They appear one clock after the fetch address is presented.

Top module: `fetch_bkpt_unit`

## Requirements
- R1: A write to word offset 0 (control) changes the global enable only when write-data bit 1 (key) is 1. The enable then takes write-data bit 0. A write with bit 1 clear leaves the enable unchanged.
- R2: Control reads as 0x10000080 with the enable placed in bit 0. Bits 31:28 read 1. The comparator count of 8 is split into bits 14:12 (upper, 0) and bits 7:4 (lower, 8). Bits 11:8 read 0, and the key bit 1 always reads 0.
- R3: Word offset 1 (remap capability) always reads 0, and writes to it have no effect.
- R4: Comparators 0..7 sit at word offsets 2..9. Each holds a 32-bit value that resets to 0 and reads back exactly as written. Bits 31:1 hold the match address and bit 0 is the mode bit.
- R5: The identification words read fixed values. They are 0x47701A03 at byte offset 0xFBC, 0x04 at 0xFD0, 0x21 at 0xFE0, 0xBD at 0xFE4, 0x0B at 0xFE8, 0x0D at 0xFF0, 0x90 at 0xFF4, 0x05 at 0xFF8, 0xB1 at 0xFFC, and 0 at 0xFCC.
- R6: A comparator matches only when the global enable is 1 and its bit 0 is 1 (breakpoint mode). A comparator with bit 0 clear never matches.
- R7: Matching compares fetch-address bits 31:1 only; fetch-address bit 0 is ignored.
- R8: When several comparators match the same fetch, one request is raised and the index is the lowest-numbered matching comparator.
- R9: Offsets not listed above read 0. Writes to read-only or unmapped offsets change no readable state.
- R10: The request and the index are registered and appear one clock after a valid fetch. The request is 0 after a cycle without fetch-valid, and the index is 0 whenever the request is 0.
- R11: Comparator writes need no key and are used for a fetch presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regOfs | input | 10 | Word offset within the 4 KB window |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regOfs (combinational) |
| fetchValid | input | 1 | Fetch address valid |
| fetchAddr | input | 32 | Instruction fetch address |
| bkptReq | output | 1 | Breakpoint request, one clock after the fetch |
| bkptIdx | output | 3 | Lowest matching comparator index |

## Verification
A corrupted comparator value or mode bit appears on the read port as soon as that offset is selected. It also appears as a missing or spurious request one clock after a fetch to the programmed address. A wrong enable shows up in control bit 0, and it changes the request on the very next matching fetch. A fault in the priority order shows as a wrong index on the cycle after a fetch that several comparators match. The bench therefore programs overlapping comparators on purpose.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int BKPT_NCOMP = 8;
  localparam int BKPT_OFS_W = 10;
  localparam int KEY_BIT    = 1;

  typedef struct packed {
    logic [BKPT_NCOMP-1:0] compWe;
    logic [31:0]           wdata;
    logic                  enable;
  } regStrobe_t;
endpackage

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
#(
  parameter int NUM_COMP = BKPT_NCOMP,
  parameter int OFS_W    = BKPT_OFS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [OFS_W-1:0] regOfs,
  input  logic [31:0]      regWdata,
  input  logic [31:0]      compRdata [NUM_COMP],
  output logic [31:0]      regRdata,
  output regStrobe_t       strobe
);
  localparam int COMP_BASE = 2;
  localparam int ID_TOP    = (1 << OFS_W) - 1;
  localparam logic [6:0] CNT = 7'(NUM_COMP);
  localparam logic [OFS_W-1:0] OFS_CTRL = '0;

  logic enableQ;
  logic ctrlHit;

  assign ctrlHit = regWr && (regOfs == OFS_CTRL);

  // keyed control register
  always_ff @(posedge clk) begin
    if (!rstN) enableQ <= 1'b0;
    else if (ctrlHit && regWdata[KEY_BIT]) enableQ <= regWdata[0];
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_COMP; gi++) begin : g_we
      assign strobe.compWe[gi] = regWr && (regOfs == OFS_W'(COMP_BASE + gi));
    end
  endgenerate
  assign strobe.wdata  = regWdata;
  assign strobe.enable = enableQ;

  function automatic logic [31:0] idWord(input logic [OFS_W-1:0] ofs);
    logic [31:0] w;
    w = '0;
    if      (ofs == OFS_W'(ID_TOP - 16)) w = 32'h4770_1A03;
    else if (ofs == OFS_W'(ID_TOP - 11)) w = 32'h04;
    else if (ofs == OFS_W'(ID_TOP - 7))  w = 32'h21;
    else if (ofs == OFS_W'(ID_TOP - 6))  w = 32'hBD;
    else if (ofs == OFS_W'(ID_TOP - 5))  w = 32'h0B;
    else if (ofs == OFS_W'(ID_TOP - 3))  w = 32'h0D;
    else if (ofs == OFS_W'(ID_TOP - 2))  w = 32'h90;
    else if (ofs == OFS_W'(ID_TOP - 1))  w = 32'h05;
    else if (ofs == OFS_W'(ID_TOP))      w = 32'hB1;
    return w;
  endfunction

  always_comb begin
    regRdata = idWord(regOfs);
    if (regOfs == OFS_CTRL)
      regRdata = {4'h1, 13'b0, CNT[6:4], 4'h0, CNT[3:0], 3'b000, enableQ};
    for (int i = 0; i < NUM_COMP; i++)
      if (regOfs == OFS_W'(COMP_BASE + i)) regRdata = compRdata[i];
  end
endmodule

// File: rtl/bkpt_dp.sv
module bkpt_dp
  import bkpt_pkg::*;
#(
  parameter int NUM_COMP = BKPT_NCOMP,
  parameter int IDX_W    = $clog2(NUM_COMP)
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic             fetchValid,
  input  logic [31:0]      fetchAddr,
  output logic [31:0]      compRdata [NUM_COMP],
  output logic             bkptReq,
  output logic [IDX_W-1:0] bkptIdx
);
  logic [31:0]         compQ [NUM_COMP];
  logic [NUM_COMP-1:0] hit;
  logic                anyHit;
  logic [IDX_W-1:0]    hitIdx;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_COMP; gi++) begin : g_comp
      always_ff @(posedge clk) begin
        if (!rstN) compQ[gi] <= '0;
        else if (strobe.compWe[gi]) compQ[gi] <= strobe.wdata;
      end
      assign compRdata[gi] = compQ[gi];
      // bit 0 of the xor carries mode vs. fetch lsb, shifted out
      assign hit[gi] = strobe.enable && compQ[gi][0] &&
                       (((fetchAddr ^ compQ[gi]) >> 1) == 32'd0);
    end
  endgenerate

  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int i = NUM_COMP - 1; i >= 0; i--)
      if (hit[i]) begin
        anyHit = 1'b1;
        hitIdx = IDX_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bkptReq <= 1'b0;
      bkptIdx <= '0;
    end else begin
      bkptReq <= fetchValid && anyHit;
      bkptIdx <= (fetchValid && anyHit) ? hitIdx : '0;
    end
  end
endmodule

// File: rtl/fetch_bkpt_unit.sv
module fetch_bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_COMP = BKPT_NCOMP,
  parameter int OFS_W    = BKPT_OFS_W,
  localparam int IDX_W   = $clog2(NUM_COMP)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [OFS_W-1:0] regOfs,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             fetchValid,
  input  logic [31:0]      fetchAddr,
  output logic             bkptReq,
  output logic [IDX_W-1:0] bkptIdx
);
  regStrobe_t  strobe;
  logic [31:0] compRdata [NUM_COMP];
  logic        globalEn;

  assign globalEn = strobe.enable;

  bkpt_ctrl #(.NUM_COMP(NUM_COMP), .OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regOfs(regOfs),
    .regWdata(regWdata), .compRdata(compRdata), .regRdata(regRdata),
    .strobe(strobe)
  );

  bkpt_dp #(.NUM_COMP(NUM_COMP), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .compRdata(compRdata), .bkptReq(bkptReq),
    .bkptIdx(bkptIdx)
  );
endmodule

// File: rtl/bkpt_checker.sv
module bkpt_checker #(
  parameter int OFS_W = 10,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic [OFS_W-1:0] regOfs,
  input logic [31:0]      regWdata,
  input logic [31:0]      regRdata,
  input logic             fetchValid,
  input logic             bkptReq,
  input logic [IDX_W-1:0] bkptIdx,
  input logic             globalEn
);
  a_r1_no_key_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regOfs == '0 && !regWdata[1]) |=> (globalEn == $past(globalEn)));

  a_r1_keyed_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regOfs == '0 && regWdata[1]) |=> (globalEn == $past(regWdata[0])));

  a_r2_ctrl_fields: assert property (@(posedge clk) disable iff (!rstN)
    (regOfs == '0) |-> (regRdata[31:1] == 31'h0800_0040 && regRdata[0] == globalEn));

  a_r3_remap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regOfs == OFS_W'(1)) |-> (regRdata == 32'd0));

  a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bkptReq) |-> $past(globalEn));

  a_r10_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    bkptReq |-> $past(fetchValid));

  a_r10_idx_idle: assert property (@(posedge clk) disable iff (!rstN)
    !bkptReq |-> (bkptIdx == '0));
endmodule

bind fetch_bkpt_unit bkpt_checker #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regOfs(regOfs),
  .regWdata(regWdata), .regRdata(regRdata), .fetchValid(fetchValid),
  .bkptReq(bkptReq), .bkptIdx(bkptIdx), .globalEn(globalEn)
);

// File: tb/test_fetch_bkpt_unit.sv
`timescale 1ns/1ps
module test_fetch_bkpt_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [9:0]  regOfs = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        bkptReq;
  logic [2:0]  bkptIdx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic       req;
    logic [2:0] idx;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  logic [31:0] mComp [8];
  logic        mEn = 1'b0;

  always #2.5 clk = ~clk;

  fetch_bkpt_unit i_fetch_bkpt_unit (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regOfs(regOfs),
    .regWdata(regWdata), .regRdata(regRdata), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .bkptReq(bkptReq), .bkptIdx(bkptIdx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per clock after a driven fetch cycle
  initial forever begin
    @(posedge clk);
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk({e.tag, " req"}, 32'(bkptReq), 32'(e.req));
      chk({e.tag, " idx"}, 32'(bkptIdx), 32'(e.idx));
    end
  end

  task automatic doFetch(input logic v, input logic [31:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    fetchValid = v;
    fetchAddr  = a;
    e.req = 1'b0;
    e.idx = '0;
    e.tag = tag;
    if (v && mEn)
      for (int i = 0; i < 8; i++)
        if (!e.req && mComp[i][0] && (mComp[i][31:1] == a[31:1])) begin
          e.req = 1'b1;
          e.idx = 3'(i);
        end
    expQ.push_back(e);
  endtask

  task automatic regWrite(input logic [9:0] ofs, input logic [31:0] d);
    @(negedge clk);
    fetchValid = 1'b0;
    regWr = 1'b1;
    regOfs = ofs;
    regWdata = d;
    if (ofs == 10'd0 && d[1]) mEn = d[0];
    if (ofs >= 10'd2 && ofs <= 10'd9) mComp[ofs - 10'd2] = d;
    @(posedge clk);
    #1 regWr = 1'b0;
  endtask

  task automatic rdCheck(input logic [9:0] ofs, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regOfs = ofs;
    #1 chk(tag, regRdata, exp);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mComp[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rdCheck(10'd0, 32'h1000_0080, "R2 reset control");
    rdCheck(10'd1, 32'h0, "R3 remap reset");
    for (int i = 0; i < 8; i++) rdCheck(10'(2 + i), 32'h0, "R4 comparator reset");
    chk("R10 reset req", 32'(bkptReq), 32'd0);

    // identification words (word offset = byte offset / 4)
    rdCheck(10'h3EF, 32'h4770_1A03, "R5 id FBC");
    rdCheck(10'h3F3, 32'h0, "R5 id FCC");
    rdCheck(10'h3F4, 32'h04, "R5 id FD0");
    rdCheck(10'h3F8, 32'h21, "R5 id FE0");
    rdCheck(10'h3F9, 32'hBD, "R5 id FE4");
    rdCheck(10'h3FA, 32'h0B, "R5 id FE8");
    rdCheck(10'h3FC, 32'h0D, "R5 id FF0");
    rdCheck(10'h3FD, 32'h90, "R5 id FF4");
    rdCheck(10'h3FE, 32'h05, "R5 id FF8");
    rdCheck(10'h3FF, 32'hB1, "R5 id FFC");
    rdCheck(10'h00A, 32'h0, "R9 unmapped low");
    rdCheck(10'h3F0, 32'h0, "R9 unmapped high");

    // comparators, written without key (R11)
    regWrite(10'd2, 32'h0000_1001);
    regWrite(10'd5, 32'h0000_2001);
    regWrite(10'd7, 32'h0000_2001);
    regWrite(10'd8, 32'h0000_3000);
    rdCheck(10'd2, 32'h0000_1001, "R4 comp0 readback");
    rdCheck(10'd8, 32'h0000_3000, "R4 comp6 readback");

    // enable without key is dropped
    regWrite(10'd0, 32'h0000_0001);
    rdCheck(10'd0, 32'h1000_0080, "R1 unkeyed write ignored");
    doFetch(1'b1, 32'h0000_1000, "R1 no match while disabled");
    doFetch(1'b0, 32'h0, "R10 idle");

    // keyed enable; key reads back 0
    regWrite(10'd0, 32'h0000_0003);
    rdCheck(10'd0, 32'h1000_0081, "R1 keyed enable R2 key reads 0");

    doFetch(1'b1, 32'h0000_1000, "R6 comp0 match");
    doFetch(1'b1, 32'h0000_1001, "R7 lsb ignored");
    doFetch(1'b1, 32'h0000_2000, "R8 lowest of comp3 comp5");
    doFetch(1'b1, 32'h0000_3000, "R6 remap-mode comparator silent");
    doFetch(1'b1, 32'h0000_1002, "R7 bit1 differs no match");
    doFetch(1'b0, 32'h0000_1000, "R10 invalid fetch no request");
    doFetch(1'b1, 32'h0000_2002, "R6 no comparator");
    doFetch(1'b0, 32'h0, "R10 idle");

    // writes to read-only / unmapped offsets
    regWrite(10'd1, 32'hFFFF_FFFF);
    rdCheck(10'd1, 32'h0, "R9 remap write ignored R3");
    regWrite(10'h3FF, 32'h1234_5678);
    rdCheck(10'h3FF, 32'hB1, "R9 id write ignored");
    regWrite(10'h00A, 32'h0000_1001);
    rdCheck(10'h00A, 32'h0, "R9 unmapped write ignored");
    doFetch(1'b1, 32'h0000_1000, "R9 comparators unaffected");
    doFetch(1'b0, 32'h0, "R10 idle");

    // comparator write used by the next-cycle fetch
    regWrite(10'd9, 32'h0000_5001);
    doFetch(1'b1, 32'h0000_5000, "R11 next-cycle use comp7");
    doFetch(1'b1, 32'h0000_1000, "R10 back-to-back fetch");
    doFetch(1'b0, 32'h0, "R10 idle");

    // keyed disable
    regWrite(10'd0, 32'h0000_0002);
    rdCheck(10'd0, 32'h1000_0080, "R1 keyed disable");
    doFetch(1'b1, 32'h0000_1000, "R6 disabled no match");
    doFetch(1'b0, 32'h0, "R10 idle");

    repeat (3) @(negedge clk);
    done = 1;
    finishRun();
  end
endmodule